// File: doc/BRIEF.md
# Masked restartable gather unit

This block fetches up to `LANES` vector elements from memory. Each element's address is a common base plus that lane's index, scaled by the element size in bytes. A lane mask picks which elements to fetch. The same mask also tracks progress: every lane that completes clears its own bit. Lanes that are not selected keep the destination value supplied at start. The unit sends one memory request at a time and works through the lanes from the lowest pending lane upward.

If a memory response carries a fault, the unit stops. It pulses a fault flag together with the number of the failing lane, and it keeps both the data already gathered and the shrunken mask. An interrupt line can also halt the gather between requests. In either case, software restarts the operation by feeding the returned mask and the partial result back in as the new mask and destination. Only the lanes still pending are then fetched, so a fetched element is never requested again and every attempt makes progress.

Top module: `gather_unit`

## Requirements
- R1: After reset, `busy`, `done`, `faultValid` and `memReqValid` are low, and `maskOut` is all zeros.
- R2: A `start` while idle captures `maskIn` and copies `dstIn` into `resultOut`. A lane whose mask bit is 0 at start keeps its `dstIn` value in `resultOut` to the end of the operation.
- R3: Requests go out one at a time, always for the lowest-numbered lane whose bit is still set in `maskOut`. The address is `baseAddr + idx*(DATA_W/8)`, where idx is bits `[i*IDX_W +: IDX_W]` of `idxVec` for lane i. No new request is issued until the previous one has been answered.
- R4: A lane whose mask bit was 0 at start is never requested. The number of requests in a fault-free run equals the number of set bits in the start mask.
- R5: A successful response writes `memRespData` into lane i of `resultOut`, where lane i is bits `[i*DATA_W +: DATA_W]`. In the same clock it clears bit i of `maskOut`.
- R6: A faulting response makes `faultValid` high for exactly one cycle, with `faultLane` set to the lowest lane still set in `maskOut`. That lane's mask bit stays set, data gathered earlier is kept, and `busy` drops.
- R7: A restart that uses the `maskOut` and `resultOut` left by a stopped run requests only the lanes still pending. Bits in `maskOut` are never set again while the unit is busy.
- R8: While `abortReq` is high, the unit issues no further request. It goes idle before its next request, without `done`, and `maskOut` shows the lanes that remain.
- R9: When the last pending lane completes, `done` goes high for one cycle and `maskOut` is all zeros.
- R10: A `start` with an all-zero `maskIn` makes `done` high in the next cycle. No request is issued and `busy` never rises.
- R11: A `start` while busy is ignored. The mask, the result and the order of requests are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a gather when idle |
| abortReq | input | 1 | Interrupt: halt before the next request |
| baseAddr | input | ADDR_W | Base byte address |
| idxVec | input | LANES*IDX_W | Per-lane element index |
| maskIn | input | LANES | Lanes to fetch |
| dstIn | input | LANES*DATA_W | Previous destination contents |
| memReqValid | output | 1 | Memory read request this cycle |
| memReqAddr | output | ADDR_W | Request byte address |
| memRespValid | input | 1 | Response for the outstanding request |
| memRespFault | input | 1 | Response reports a fault |
| memRespData | input | DATA_W | Read data |
| busy | output | 1 | Gather in progress |
| done | output | 1 | One-cycle pulse: all lanes complete |
| faultValid | output | 1 | One-cycle pulse: a fault stopped the gather |
| faultLane | output | $clog2(LANES) | Lane that faulted |
| maskOut | output | LANES | Lanes still pending |
| resultOut | output | LANES*DATA_W | Gathered data |

## Verification
The assertions assume that the memory answers each request exactly once. They also assume it raises `memRespValid` only after a request and before the next one, and never while the unit is idle. The bench memory model meets this by design. It latches each request and answers it after a fixed number of cycles chosen per test. It never raises `memRespValid` without an outstanding request. `start` and `abortReq` are driven freely, including a start that lands while the unit is busy. A behavioural model predicts every output cycle by cycle.

// File: rtl/gather_pkg.sv
package gather_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } gatherState_t;

  typedef struct packed {
    logic load;
    logic commit;
  } gatherStrb_t;
endpackage

// File: rtl/gather_datapath.sv
module gather_datapath
  import gather_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANE_W = $clog2(LANES),
  localparam int ELEM_BYTES = DATA_W / 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  gatherStrb_t              strb,
  input  logic [ADDR_W-1:0]        baseAddr,
  input  logic [LANES*IDX_W-1:0]   idxVec,
  input  logic [LANES-1:0]         maskIn,
  input  logic [LANES*DATA_W-1:0]  dstIn,
  input  logic [DATA_W-1:0]        memRespData,
  output logic [LANES-1:0]         maskQ,
  output logic [LANES*DATA_W-1:0]  resultQ,
  output logic [LANE_W-1:0]        pendLane,
  output logic                     lastPend,
  output logic [ADDR_W-1:0]        reqAddr
);
  logic [LANES*IDX_W-1:0] idxQ;
  logic [ADDR_W-1:0]      baseQ;
  logic [IDX_W-1:0]       curIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ  <= '0;
      baseQ <= '0;
    end else if (strb.load) begin
      idxQ  <= idxVec;
      baseQ <= baseAddr;
    end
  end

  // lowest pending lane wins
  always_comb begin
    pendLane = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (maskQ[i]) pendLane = LANE_W'(i);
    end
  end

  assign lastPend = (maskQ & (maskQ - LANES'(1))) == '0;
  assign curIdx   = idxQ[pendLane*IDX_W +: IDX_W];
  assign reqAddr  = baseQ + ADDR_W'(curIdx) * ADDR_W'(ELEM_BYTES);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskQ[g] <= 1'b0;
        resultQ[g*DATA_W +: DATA_W] <= '0;
      end else if (strb.load) begin
        maskQ[g] <= maskIn[g];
        resultQ[g*DATA_W +: DATA_W] <= dstIn[g*DATA_W +: DATA_W];
      end else if (strb.commit && pendLane == LANE_W'(g)) begin
        maskQ[g] <= 1'b0;
        resultQ[g*DATA_W +: DATA_W] <= memRespData;
      end
    end
  end

  // each completed lane removes exactly one pending bit
  assert_commit_shrinks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !strb.load) |=> $countones(maskQ) == $countones($past(maskQ)) - 1);
endmodule

// File: rtl/gather_ctrl.sv
module gather_ctrl
  import gather_pkg::*;
#(
  parameter int LANES = 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              startEmpty,
  input  logic              abortReq,
  input  logic              memRespValid,
  input  logic              memRespFault,
  input  logic              lastPend,
  input  logic [LANE_W-1:0] pendLane,
  output gatherStrb_t       strb,
  output logic              memReqValid,
  output logic              busy,
  output logic              done,
  output logic              faultValid,
  output logic [LANE_W-1:0] faultLane
);
  gatherState_t state;

  always_comb begin
    strb.load   = (state == ST_IDLE) && start;
    strb.commit = (state == ST_WAIT) && memRespValid && !memRespFault;
  end

  assign memReqValid = (state == ST_REQ) && !abortReq;
  assign busy        = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      faultValid <= 1'b0;
      faultLane  <= '0;
    end else begin
      done       <= 1'b0;
      faultValid <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          if (startEmpty) done <= 1'b1;
          else            state <= ST_REQ;
        end
        ST_REQ: state <= abortReq ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (memRespValid) begin
          if (memRespFault) begin
            faultValid <= 1'b1;
            faultLane  <= pendLane;
            state      <= ST_IDLE;
          end else if (lastPend) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // a fault always leaves the unit idle
  assert_fault_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> !busy);
  // abort in the request slot prevents any request and ends the run
  assert_abort_stops_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REQ && abortReq) |=> !busy && !done);
endmodule

// File: rtl/gather_unit.sv
module gather_unit
  import gather_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    abortReq,
  input  logic [ADDR_W-1:0]       baseAddr,
  input  logic [LANES*IDX_W-1:0]  idxVec,
  input  logic [LANES-1:0]        maskIn,
  input  logic [LANES*DATA_W-1:0] dstIn,
  output logic                    memReqValid,
  output logic [ADDR_W-1:0]       memReqAddr,
  input  logic                    memRespValid,
  input  logic                    memRespFault,
  input  logic [DATA_W-1:0]       memRespData,
  output logic                    busy,
  output logic                    done,
  output logic                    faultValid,
  output logic [LANE_W-1:0]       faultLane,
  output logic [LANES-1:0]        maskOut,
  output logic [LANES*DATA_W-1:0] resultOut
);
  gatherStrb_t       strb;
  logic [LANE_W-1:0] pendLane;
  logic              lastPend;

  gather_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .startEmpty(maskIn == '0),
    .abortReq(abortReq), .memRespValid(memRespValid), .memRespFault(memRespFault),
    .lastPend(lastPend), .pendLane(pendLane), .strb(strb),
    .memReqValid(memReqValid), .busy(busy), .done(done),
    .faultValid(faultValid), .faultLane(faultLane)
  );

  gather_datapath #(.LANES(LANES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .baseAddr(baseAddr), .idxVec(idxVec),
    .maskIn(maskIn), .dstIn(dstIn), .memRespData(memRespData), .maskQ(maskOut),
    .resultQ(resultOut), .pendLane(pendLane), .lastPend(lastPend), .reqAddr(memReqAddr)
  );

  assert_fault_lowest_R6: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> maskOut[faultLane] &&
                   ((maskOut & ((LANES'(1) << faultLane) - LANES'(1))) == '0));
  assert_done_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> maskOut == '0);
  assert_req_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy && maskOut != '0);
  assert_no_regrow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (maskOut & ~$past(maskOut)) == '0);
  assert_empty_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && maskIn == '0) |=> done && !busy && !memReqValid);
endmodule

// File: tb/sim_gather_unit.sv
module sim_gather_unit;
  localparam int L = 8, IW = 16, AW = 32, DW = 32, LW = 3;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, abortReq = 1'b0;
  logic [AW-1:0] baseAddr = '0;
  logic [L*IW-1:0] idxVec = '0;
  logic [L-1:0] maskIn = '0;
  logic [L*DW-1:0] dstIn = '0;
  logic memReqValid, memRespValid = 1'b0, memRespFault = 1'b0;
  logic [AW-1:0] memReqAddr;
  logic [DW-1:0] memRespData = '0;
  logic busy, done, faultValid;
  logic [LW-1:0] faultLane;
  logic [L-1:0] maskOut;
  logic [L*DW-1:0] resultOut;

  always #2 clk = ~clk;

  gather_unit #(.LANES(L), .IDX_W(IW), .ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  int checks = 0, fails = 0, cycles = 0, lat = 1, reqCount = 0, waitCnt = 0;
  logic faultEn = 1'b0, reqSeen = 1'b0, doneSeen = 1'b0;
  logic [AW-1:0] faultAddr = '0, latAddr = '0;

  // behavioural reference
  logic mBusy = 0, mReq = 0, mWait = 0, expDone = 0, expFault = 0;
  logic [L-1:0] mMask = '0;
  logic [L*DW-1:0] mRes = '0;
  int mLane = 0, expLane = 0;

  function automatic int lowest(logic [L-1:0] m);
    for (int i = 0; i < L; i++) if (m[i]) return i;
    return 0;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [L*DW-1:0] act, input logic [L*DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    expDone = 0; expFault = 0;
    if (!rstN) begin
      mBusy = 0; mReq = 0; mWait = 0; mMask = '0; mRes = '0;
    end else if (mReq) begin
      mReq = 0;
      if (abortReq) mBusy = 0; else mWait = 1;
    end else if (mWait) begin
      if (memRespValid) begin
        mWait = 0;
        if (memRespFault) begin
          expFault = 1; expLane = mLane; mBusy = 0;
        end else begin
          mMask[mLane] = 1'b0;
          mRes[mLane*DW +: DW] = memRespData;
          if (mMask == '0) begin expDone = 1; mBusy = 0; end
          else begin mReq = 1; mLane = lowest(mMask); end
        end
      end
    end else if (start) begin
      mRes = dstIn; mMask = maskIn;
      if (maskIn == '0) expDone = 1;
      else begin mBusy = 1; mReq = 1; mLane = lowest(maskIn); end
    end
  end

  // memory responder
  always @(posedge clk) begin
    memRespValid <= 1'b0; memRespFault <= 1'b0;
    if (!rstN) waitCnt = 0;
    else begin
      if (waitCnt > 0) begin
        waitCnt--;
        if (waitCnt == 0) begin
          memRespValid <= 1'b1;
          memRespFault <= faultEn && (latAddr == faultAddr);
          memRespData  <= (latAddr * 3) ^ 32'h5a5a;
        end
      end
      if (reqSeen) waitCnt = lat;
    end
  end

  // compare on every cycle away from the active edge
  always @(negedge clk) begin
    logic [AW-1:0] eAddr;
    cycles++;
    reqSeen = memReqValid;
    if (memReqValid) begin latAddr = memReqAddr; reqCount++; end
    if (done) doneSeen = 1'b1;
    if (rstN) begin
      eAddr = baseAddr + AW'(idxVec[mLane*IW +: IW]) * 4;
      chk(busy == mBusy, "R11 busy", L*DW'(busy), L*DW'(mBusy));
      chk(maskOut == mMask, "R5 maskOut", L*DW'(maskOut), L*DW'(mMask));
      chk(resultOut == mRes, "R2 resultOut", resultOut, mRes);
      chk(done == expDone, "R9 done", L*DW'(done), L*DW'(expDone));
      chk(faultValid == expFault, "R6 faultValid", L*DW'(faultValid), L*DW'(expFault));
      if (expFault) chk(faultLane == LW'(expLane), "R6 faultLane", L*DW'(faultLane), L*DW'(expLane));
      chk(memReqValid == (mReq && !abortReq), "R3 memReqValid", L*DW'(memReqValid), L*DW'(mReq && !abortReq));
      if (memReqValid) chk(memReqAddr == eAddr, "R3 memReqAddr", L*DW'(memReqAddr), L*DW'(eAddr));
    end
  end

  always @(posedge clk) if (cycles > 50000) begin
    fails++;
    $display("FAIL watchdog actual=%0d expected=<50000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic begin_run(input logic [L-1:0] m, input int seed, input logic keepDst);
    @(negedge clk);
    baseAddr = 32'h1000 + seed * 32'h100;
    for (int i = 0; i < L; i++) begin
      idxVec[i*IW +: IW] = IW'(i * 37 + seed * 11 + 3);
      if (!keepDst) dstIn[i*DW +: DW] = 32'hD000_0000 + i + seed * 16;
    end
    maskIn = m; start = 1'b1; reqCount = 0; doneSeen = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [L-1:0] left;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !faultValid && !memReqValid && maskOut == '0, "R1 reset", L*DW'(maskOut), '0);
    rstN = 1'b1;

    // full mask, short latency
    lat = 1; begin_run(8'hFF, 1, 0); wait_idle();
    chk(doneSeen && maskOut == '0, "R9 full run", L*DW'(maskOut), '0);

    // sparse mask: only set lanes requested
    lat = 3; begin_run(8'b1010_0110, 2, 0); wait_idle();
    chk(reqCount == 4, "R4 request count", L*DW'(reqCount), 4);

    // fault in lane 3, then restart with what remains
    lat = 2; faultEn = 1'b1; faultAddr = 32'h1000 + 32'h300 + (3 * 37 + 33 + 3) * 4;
    begin_run(8'hFF, 3, 0); wait_idle();
    chk(maskOut == 8'hF8, "R6 mask after fault", L*DW'(maskOut), L*DW'(8'hF8));
    faultEn = 1'b0; left = maskOut; dstIn = resultOut;
    begin_run(left, 3, 1); wait_idle();
    chk(reqCount == 5, "R7 restart requests", L*DW'(reqCount), 5);

    // fault on the very first lane
    faultEn = 1'b1; faultAddr = 32'h1000 + 32'h400 + (37 + 44 + 3) * 4;
    lat = 1; begin_run(8'b0110_0010, 4, 0); wait_idle();
    chk(reqCount == 1 && maskOut == 8'b0110_0010, "R6 first-lane fault", L*DW'(maskOut), L*DW'(8'b0110_0010));
    faultEn = 1'b0;

    // empty mask
    begin_run(8'h00, 5, 0); wait_idle();
    chk(reqCount == 0 && doneSeen, "R10 empty start", L*DW'(reqCount), 0);

    // interrupt part-way, then resume
    lat = 2; begin_run(8'hFF, 6, 0);
    repeat (4) @(negedge clk);
    abortReq = 1'b1; wait_idle(); abortReq = 1'b0;
    chk(maskOut != '0 && !doneSeen, "R8 abort leaves pending", L*DW'(maskOut), L*DW'(1));
    left = maskOut; dstIn = resultOut;
    begin_run(left, 6, 1); wait_idle();
    chk(doneSeen && reqCount == $countones(left), "R7 resume after abort", L*DW'(reqCount), L*DW'($countones(left)));

    // start pulse while busy is ignored
    lat = 2; begin_run(8'h3C, 7, 0);
    @(negedge clk); maskIn = 8'h01; start = 1'b1; @(negedge clk); start = 1'b0;
    wait_idle();
    chk(reqCount == 4, "R11 start while busy", L*DW'(reqCount), 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule